// File: doc/BRIEF.md
# Sliced 16-Bit Arithmetic-Logic Unit with Carry Lookahead

This block is a purely combinational 16-bit arithmetic-logic unit. The datapath is cut into four identical 4-bit slices. Slices 0 and 1 cover the low byte and slices 2 and 3 cover the high byte. Each slice decodes a 4-bit function select and a mode bit, and forms a per-bit propagate term and a per-bit generate term from its operand bits. From these it derives its 4-bit result and a group propagate/generate pair. These pairs are meaningful for every select code, not only for plain addition.

A shared lookahead unit takes the four group pairs and the incoming carry. It forms the carry into slices 1, 2 and 3 in two-level form, with no ripple through the slices, and also forms the 16-bit carry-out. A surrounding datapath drives the operands and control in the same cycle and reads the result, the carry-out and an all-ones equality flag.

Top module: `alu16_sliced`

## Requirements
- R1: `logic_i` = 0 selects arithmetic mode and `logic_i` = 1 selects bitwise logic mode, for the same select code.
- R2: In arithmetic mode, `y_o` = (X + Y + `cin_i`) mod 65536, where (X, Y) depend on `fsel_i`: 0:(A,0), 1:(A|B,0), 2:(A|~B,0), 3:(FFFF,0), 4:(A,A&~B), 5:(A|B,A&~B), 6:(A,~B), 7:(FFFF,A&~B), 8:(A,A&B), 9:(A,B), 10:(A|~B,A&B), 11:(FFFF,A&B), 12:(A,A), 13:(A|B,A), 14:(A|~B,A), 15:(FFFF,A).
- R3: In logic mode, `y_o` is bitwise, with `fsel_i` codes 0:~A, 1:~(A|B), 2:~A&B, 3:0000, 4:~(A&B), 5:~B, 6:A^B, 7:A&~B, 8:~A|B, 9:~(A^B), 10:B, 11:A&B, 12:FFFF, 13:A|~B, 14:A|B, 15:A.
- R4: In logic mode, `cin_i` has no effect on `y_o`.
- R5: In both modes, `cout_o` equals bit 16 of the 17-bit sum X + Y + `cin_i` for the R2 pair of the current select code.
- R6: `eq_o` is 1 exactly when all 16 bits of `y_o` are 1. In particular, with arithmetic code 6 and `cin_i` = 0, `eq_o` is 1 exactly when A equals B.
- R7: A carry produced at the bottom of the word reaches every higher slice in the same evaluation. For example, code 9 with A=FFFF, B=0000 and `cin_i`=1 gives `y_o`=0000 and `cout_o`=1. The carry into slice 2 equals the carry out of the low-byte sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| fsel_i | input | 4 | Function select code |
| logic_i | input | 1 | 1 = bitwise logic mode, 0 = arithmetic mode |
| cin_i | input | 1 | Carry-in, high adds one in arithmetic mode |
| y_o | output | 16 | Result |
| cout_o | output | 1 | Carry-out from the lookahead unit |
| eq_o | output | 1 | High when the result is all ones |

## Verification
The carry-out and the equality flag are both derived from the same evaluation. They can therefore change together, and some vectors drive them to opposite extremes: subtract code 6 with equal operands gives an all-ones result with no carry when `cin_i` is low, and a zero result with a carry when `cin_i` is high. The bench drives every select and mode against the corner operands 0000, FFFF, 8000 and 7FFF, plus random operands, with both carry-in values. It compares the result, carry-out and flag in the same half-cycle against a behavioural table of the select functions.

// File: rtl/alu16_sliced.sv
module alu16_sliced #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   fsel_i,
  input  logic         logic_i,
  input  logic         cin_i,
  output logic [W-1:0] y_o,
  output logic         cout_o,
  output logic         eq_o
);
  localparam int NS = W / 4;

  logic [NS-1:0] sp, sg;
  logic [NS:0]   c;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    logic [3:0] a, b, t, u, ci;
    assign a = a_i[4*k +: 4];
    assign b = b_i[4*k +: 4];
    assign t = a | (b & {4{fsel_i[0]}}) | (~b & {4{fsel_i[1]}});
    assign u = (a & b & {4{fsel_i[3]}}) | (a & ~b & {4{fsel_i[2]}});
    assign ci[0] = c[k];
    assign ci[1] = u[0] | (t[0] & c[k]);
    assign ci[2] = u[1] | (t[1] & u[0]) | (t[1] & t[0] & c[k]);
    assign ci[3] = u[2] | (t[2] & u[1]) | (t[2] & t[1] & u[0])
                 | (t[2] & t[1] & t[0] & c[k]);
    assign sp[k] = &t;
    assign sg[k] = u[3] | (t[3] & u[2]) | (t[3] & t[2] & u[1])
                 | (t[3] & t[2] & t[1] & u[0]);
    assign y_o[4*k +: 4] = logic_i ? ~(t ^ u) : (t ^ u ^ ci);
  end

  logic gp, gg;
  assign c[0] = cin_i;
  assign c[1] = sg[0] | (sp[0] & cin_i);
  assign c[2] = sg[1] | (sp[1] & sg[0]) | (sp[1] & sp[0] & cin_i);
  assign c[3] = sg[2] | (sp[2] & sg[1]) | (sp[2] & sp[1] & sg[0])
              | (sp[2] & sp[1] & sp[0] & cin_i);
  assign gp = &sp;
  assign gg = sg[3] | (sp[3] & sg[2]) | (sp[3] & sp[2] & sg[1])
            | (sp[3] & sp[2] & sp[1] & sg[0]);
  assign c[4]   = gg | (gp & cin_i);
  assign cout_o = c[4];
  assign eq_o   = &y_o;
endmodule

// File: rtl/alu16_sliced_chk.sv
module alu16_sliced_chk (
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic [3:0]  fsel_i,
  input logic        logic_i,
  input logic        cin_i,
  input logic [15:0] y_o,
  input logic        cout_o,
  input logic        eq_o,
  input logic [4:0]  c
);
  logic known;
  logic [16:0] add_full;
  logic [8:0]  add_low;
  assign known    = !$isunknown({a_i, b_i, fsel_i, logic_i, cin_i});
  assign add_full = {1'b0, a_i} + {1'b0, b_i} + {16'd0, cin_i};
  assign add_low  = {1'b0, a_i[7:0]} + {1'b0, b_i[7:0]} + {8'd0, cin_i};

  always_comb begin
    if (known && !logic_i && fsel_i == 4'd9)
      p_add_sum_r2: assert ({cout_o, y_o} == add_full);
    if (known && logic_i && fsel_i == 4'd6)
      p_logic_xor_r3: assert (y_o == (a_i ^ b_i));
    if (known && logic_i && fsel_i == 4'd0)
      p_logic_not_r4: assert (y_o == ~a_i);
    if (known && fsel_i == 4'd12)
      p_double_carry_r5: assert (cout_o == a_i[15]);
    if (known && !logic_i && fsel_i == 4'd6 && !cin_i)
      p_equal_flag_r6: assert (eq_o == (a_i == b_i));
    if (known && !logic_i && fsel_i == 4'd9)
      p_byte_carry_r7: assert (c[2] == add_low[8]);
  end
endmodule

bind alu16_sliced alu16_sliced_chk chk (
  .a_i(a_i), .b_i(b_i), .fsel_i(fsel_i), .logic_i(logic_i), .cin_i(cin_i),
  .y_o(y_o), .cout_o(cout_o), .eq_o(eq_o), .c(c)
);

// File: tb/tb_alu16_sliced.sv
module tb_alu16_sliced;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] a, b, y;
  logic [3:0]  fsel;
  logic        lmode, cin, cout, eq;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_sliced dut (
    .a_i(a), .b_i(b), .fsel_i(fsel), .logic_i(lmode), .cin_i(cin),
    .y_o(y), .cout_o(cout), .eq_o(eq)
  );

  function automatic logic [16:0] arith_ref(input logic [15:0] x, input logic [15:0] z,
                                            input logic [3:0] s, input logic ci);
    logic [15:0] p, q;
    case (s)
      4'd0:  begin p = x;         q = 16'h0;   end
      4'd1:  begin p = x | z;     q = 16'h0;   end
      4'd2:  begin p = x | ~z;    q = 16'h0;   end
      4'd3:  begin p = 16'hFFFF;  q = 16'h0;   end
      4'd4:  begin p = x;         q = x & ~z;  end
      4'd5:  begin p = x | z;     q = x & ~z;  end
      4'd6:  begin p = x;         q = ~z;      end
      4'd7:  begin p = 16'hFFFF;  q = x & ~z;  end
      4'd8:  begin p = x;         q = x & z;   end
      4'd9:  begin p = x;         q = z;       end
      4'd10: begin p = x | ~z;    q = x & z;   end
      4'd11: begin p = 16'hFFFF;  q = x & z;   end
      4'd12: begin p = x;         q = x;       end
      4'd13: begin p = x | z;     q = x;       end
      4'd14: begin p = x | ~z;    q = x;       end
      default: begin p = 16'hFFFF; q = x;      end
    endcase
    return {1'b0, p} + {1'b0, q} + {16'd0, ci};
  endfunction

  function automatic logic [15:0] logic_ref(input logic [15:0] x, input logic [15:0] z,
                                            input logic [3:0] s);
    case (s)
      4'd0:  return ~x;
      4'd1:  return ~(x | z);
      4'd2:  return ~x & z;
      4'd3:  return 16'h0000;
      4'd4:  return ~(x & z);
      4'd5:  return ~z;
      4'd6:  return x ^ z;
      4'd7:  return x & ~z;
      4'd8:  return ~x | z;
      4'd9:  return ~(x ^ z);
      4'd10: return z;
      4'd11: return x & z;
      4'd12: return 16'hFFFF;
      4'd13: return x | ~z;
      4'd14: return x | z;
      default: return x;
    endcase
  endfunction

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h sel=%0d mode=%0d cin=%0d actual=%h expected=%h",
               req, a, b, fsel, lmode, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] z, input logic [3:0] s,
                       input logic m, input logic ci);
    logic [16:0] ar;
    logic [15:0] ey;
    @(posedge clk);
    a = x; b = z; fsel = s; lmode = m; cin = ci;
    ar = arith_ref(x, z, s, ci);
    ey = m ? logic_ref(x, z, s) : ar[15:0];
    @(negedge clk);
    check(m ? (ci ? "R4" : "R3") : "R2", {1'b0, y}, {1'b0, ey});
    check("R5", {16'd0, cout}, {16'd0, ar[16]});
    check("R6", {16'd0, eq}, {16'd0, (ey == 16'hFFFF)});
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles >= WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] corner [4];
    logic [15:0] y_arith;
    corner[0] = 16'h0000; corner[1] = 16'hFFFF;
    corner[2] = 16'h8000; corner[3] = 16'h7FFF;
    a = '0; b = '0; fsel = '0; lmode = 1'b0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2", {y, cout, eq}, 19'd0 >> 2);

    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
              apply(corner[i], corner[j], 4'(s), m[0], ci[0]);

    for (int n = 0; n < 40; n++)
      for (int s = 0; s < 16; s++)
        for (int m = 0; m < 2; m++)
          apply(16'($urandom), 16'($urandom), 4'(s), m[0], 1'($urandom));

    // R1: same operands and code, mode alone switches the function
    apply(16'h1234, 16'h1234, 4'd9, 1'b0, 1'b0);
    y_arith = y;
    check("R1", {1'b0, y_arith}, 17'h02468);
    apply(16'h1234, 16'h1234, 4'd9, 1'b1, 1'b0);
    check("R1", {1'b0, y}, 17'h0FFFF);

    // R6: equality flag and carry in the same evaluation
    apply(16'hBEEF, 16'hBEEF, 4'd6, 1'b0, 1'b0);
    check("R6", {15'd0, eq, cout}, 17'd2);
    apply(16'hBEEF, 16'hBEEF, 4'd6, 1'b0, 1'b1);
    check("R6", {y, eq}, 17'd0);
    check("R5", {16'd0, cout}, 17'd1);
    apply(16'hBEEF, 16'hBEEE, 4'd6, 1'b0, 1'b0);
    check("R6", {16'd0, eq}, 17'd0);

    // R7: carry through all four slices
    apply(16'hFFFF, 16'h0000, 4'd9, 1'b0, 1'b1);
    check("R7", {cout, y}, 17'h10000);
    apply(16'h00FF, 16'h0000, 4'd9, 1'b0, 1'b1);
    check("R7", {cout, y}, 17'h00100);
    apply(16'h0FFF, 16'h0001, 4'd9, 1'b0, 1'b0);
    check("R7", {cout, y}, 17'h01000);

    // R4: cin toggled in logic mode leaves the result unchanged
    apply(16'hA5C3, 16'h3C5A, 4'd14, 1'b1, 1'b0);
    y_arith = y;
    apply(16'hA5C3, 16'h3C5A, 4'd14, 1'b1, 1'b1);
    check("R4", {1'b0, y}, {1'b0, y_arith});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule